// File: doc/BRIEF.md
# Banked-Accumulator Multiply/Divide Unit

This block is the integer multiply/divide engine of a 32-bit core. It holds four 64-bit accumulators, each a HI/LO pair of 32-bit halves. Accumulator 0 is the ordinary HI/LO that every program uses. Accumulators 1 to 3 are extra banks that may only be touched while the signal-processing extension is enabled. The core presents a decoded operation code, a 2-bit accumulator index, two 32-bit operands and a flag that marks a move-from whose destination is register zero. It then pulses `start`.

Multiplies, multiply-accumulates and the HI/LO moves finish in one cycle. Divides run a restoring loop of 32 steps, during which `busy` is high and further requests are dropped. A divide always lands in accumulator 0, whatever index is presented. A zero divisor is replaced by 1, and so is the signed overflow pair (most negative dividend with divisor -1), so a divide never traps. An access to a nonzero bank while the extension is off raises `dsp_exc` and leaves all state alone.

Top module: `acc_mdu`

## Requirements
- R1: After reset all four accumulators read zero, and `busy`, `done`, `dsp_exc` and `rd_val` are 0.
- R2: Operation codes are 0 signed multiply and 1 unsigned multiply. The low 32 bits of the 64-bit product go to LO and the high 32 bits to HI of the indexed accumulator. `done` is high on the cycle after the accepted `start`.
- R3: Codes 2/3 (signed/unsigned multiply-add) add the product to the 64-bit {HI,LO}. Codes 4/5 (signed/unsigned multiply-subtract) subtract it. Both wrap modulo 2^64.
- R4: Code 8 writes `opa` into HI only and code 9 writes `opa` into LO only, in the indexed accumulator. The other half keeps its value.
- R5: Code 10 returns HI and code 11 returns LO of the indexed accumulator on `rd_val` the cycle after `start`. `rd_val` holds that value until the next move-from that is carried out.
- R6: Any operation other than a divide or a register-zero move-from, with a nonzero index and `dsp_en` low, pulses `dsp_exc` and `done` for one cycle. It changes no accumulator and leaves `rd_val` unchanged.
- R7: A move-from with `dst_zero` high is a no-op. It performs no check, raises no exception and leaves `rd_val` unchanged. It still pulses `done`.
- R8: Codes 6 (signed) and 7 (unsigned) divide `opa` by `opb`. They write the quotient to LO and the remainder to HI of accumulator 0 for any index, and they never raise `dsp_exc`.
- R9: A signed quotient truncates toward zero, and the remainder takes the sign of the dividend.
- R10: A zero divisor is replaced by 1 for both signed and unsigned divides, so LO receives the dividend and HI receives 0.
- R11: A signed divide of 0x80000000 by 0xFFFFFFFF uses divisor 1. It yields LO = 0x80000000 and HI = 0.
- R12: After an accepted divide `busy` is high for exactly 32 cycles, then `done` pulses. A `start` while `busy` is high is ignored and changes no state.
- R13: With `dsp_en` high, accumulators 1 to 3 are written and read independently of each other and of accumulator 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, one cycle |
| op | input | 4 | Operation code (see requirements) |
| acc_idx | input | 2 | Accumulator bank index |
| dsp_en | input | 1 | Extension enable; permits banks 1 to 3 |
| dst_zero | input | 1 | Move-from targets register zero |
| opa | input | 32 | First operand / dividend / move-to data |
| opb | input | 32 | Second operand / divisor |
| busy | output | 1 | Divide in progress |
| done | output | 1 | Completion pulse |
| dsp_exc | output | 1 | Illegal-bank exception pulse |
| rd_val | output | 32 | Result of the last move-from |

## Verification
The bench goes after the divisor substitution cases: a zero divisor and the signed overflow pair. A divider that skipped the substitution would return an all-ones quotient or a wrong sign there. It divides with nonzero indices and with the extension off, which catches a design that writes the indexed bank or raises an exception on a divide. It checks that an illegal request and an ignored request while busy leave the accumulators and `rd_val` untouched. It also checks that a register-zero move-from escapes the bank check. The signed divide cases use mixed signs to expose wrong quotient rounding or remainder sign. The busy window is counted exactly, so an off-by-one step count fails.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [3:0] {
    OP_MULS  = 4'd0,
    OP_MULU  = 4'd1,
    OP_MADDS = 4'd2,
    OP_MADDU = 4'd3,
    OP_MSUBS = 4'd4,
    OP_MSUBU = 4'd5,
    OP_DIVS  = 4'd6,
    OP_DIVU  = 4'd7,
    OP_MTHI  = 4'd8,
    OP_MTLO  = 4'd9,
    OP_MFHI  = 4'd10,
    OP_MFLO  = 4'd11
  } mdu_op_e;

  function automatic logic op_is_div(mdu_op_e o);
    return (o == OP_DIVS) || (o == OP_DIVU);
  endfunction

  function automatic logic op_is_mf(mdu_op_e o);
    return (o == OP_MFHI) || (o == OP_MFLO);
  endfunction

  function automatic logic op_is_signed(mdu_op_e o);
    return (o == OP_MULS) || (o == OP_MADDS) || (o == OP_MSUBS) || (o == OP_DIVS);
  endfunction
endpackage

// File: rtl/mdu_acc_bank.sv
module mdu_acc_bank #(
  parameter int W    = 32,
  parameter int NACC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NACC)-1:0] rd_idx,
  output logic [W-1:0]            rd_hi,
  output logic [W-1:0]            rd_lo,
  input  logic                    wr_en,
  input  logic [$clog2(NACC)-1:0] wr_idx,
  input  logic                    wr_hi_en,
  input  logic                    wr_lo_en,
  input  logic [W-1:0]            wr_hi,
  input  logic [W-1:0]            wr_lo
);
  logic [W-1:0] hi_q [NACC];
  logic [W-1:0] lo_q [NACC];

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    logic sel;
    assign sel = wr_en && (wr_idx == g[$clog2(NACC)-1:0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[g] <= '0;
        lo_q[g] <= '0;
      end else begin
        if (sel && wr_hi_en) hi_q[g] <= wr_hi;
        if (sel && wr_lo_en) lo_q[g] <= wr_lo;
      end
    end
  end

  assign rd_hi = hi_q[rd_idx];
  assign rd_lo = lo_q[rd_idx];
endmodule

// File: rtl/mdu_mulacc.sv
module mdu_mulacc
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  mdu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] cur_hi,
  input  logic [W-1:0] cur_lo,
  output logic         hi_en,
  output logic         lo_en,
  output logic [W-1:0] nxt_hi,
  output logic [W-1:0] nxt_lo
);
  localparam int PW = 2 * W;

  function automatic logic [PW-1:0] wide_mul(logic [W-1:0] x, logic [W-1:0] y, logic sgn);
    logic [PW-1:0] ex, ey;
    ex = sgn ? {{W{x[W-1]}}, x} : {{W{1'b0}}, x};
    ey = sgn ? {{W{y[W-1]}}, y} : {{W{1'b0}}, y};
    return ex * ey;
  endfunction

  logic [PW-1:0] prod, acc, res;

  always_comb begin
    prod  = wide_mul(a, b, op_is_signed(op));
    acc   = {cur_hi, cur_lo};
    res   = acc;
    hi_en = 1'b0;
    lo_en = 1'b0;
    unique case (op)
      OP_MULS, OP_MULU:   begin res = prod;        hi_en = 1'b1; lo_en = 1'b1; end
      OP_MADDS, OP_MADDU: begin res = acc + prod;  hi_en = 1'b1; lo_en = 1'b1; end
      OP_MSUBS, OP_MSUBU: begin res = acc - prod;  hi_en = 1'b1; lo_en = 1'b1; end
      OP_MTHI:            begin res = {a, cur_lo}; hi_en = 1'b1; end
      OP_MTLO:            begin res = {cur_hi, a}; lo_en = 1'b1; end
      default: ;
    endcase
    nxt_hi = res[PW-1:W];
    nxt_lo = res[W-1:0];
  end
endmodule

// File: rtl/mdu_divider.sv
module mdu_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         launch,
  input  logic         sgn,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         last,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W-1:0] safe_divisor(logic [W-1:0] x, logic [W-1:0] y, logic s);
    if (y == '0) return W'(1);
    if (s && x == MOST_NEG && y == '1) return W'(1);
    return y;
  endfunction

  function automatic logic [W-1:0] magnitude(logic [W-1:0] x, logic s);
    return (s && x[W-1]) ? (~x + W'(1)) : x;
  endfunction

  logic          busy_q, nq_q, nr_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [W-1:0]  fixed_b;
  logic [W:0]    shifted, trial;
  logic          fits;
  logic [W-1:0]  rem_n, quo_n;

  assign fixed_b = safe_divisor(dividend, divisor, sgn);
  assign shifted = {rem_q, quo_q[W-1]};
  assign trial   = shifted - {1'b0, dvs_q};
  assign fits    = !trial[W];
  assign rem_n   = fits ? trial[W-1:0] : shifted[W-1:0];
  assign quo_n   = {quo_q[W-2:0], fits};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      nq_q   <= 1'b0;
      nr_q   <= 1'b0;
    end else if (launch && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(W);
      rem_q  <= '0;
      quo_q  <= magnitude(dividend, sgn);
      dvs_q  <= magnitude(fixed_b, sgn);
      nq_q   <= sgn && (dividend[W-1] ^ fixed_b[W-1]);
      nr_q   <= sgn && dividend[W-1];
    end else if (busy_q) begin
      cnt_q <= cnt_q - CW'(1);
      rem_q <= rem_n;
      quo_q <= quo_n;
      if (last) busy_q <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign last = busy_q && (cnt_q == CW'(1));
  assign quot = nq_q ? (~quo_n + W'(1)) : quo_n;
  assign rem  = nr_q ? (~rem_n + W'(1)) : rem_n;

  // R12
  last_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy_q);
  // R12
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> busy_q);
  // R12
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !busy_q) |=> (busy_q && cnt_q == CW'(W)));
endmodule

// File: rtl/acc_mdu.sv
module acc_mdu
  import mdu_pkg::*;
#(
  parameter int W    = 32,
  parameter int NACC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [3:0]              op,
  input  logic [$clog2(NACC)-1:0] acc_idx,
  input  logic                    dsp_en,
  input  logic                    dst_zero,
  input  logic [W-1:0]            opa,
  input  logic [W-1:0]            opb,
  output logic                    busy,
  output logic                    done,
  output logic                    dsp_exc,
  output logic [W-1:0]            rd_val
);
  localparam int IW = $clog2(NACC);

  mdu_op_e op_e;
  logic    accept, is_div, is_mf, mf_nop, needs_chk, illegal, op_fire, div_launch;
  logic    div_busy, div_last;
  logic [W-1:0] dq, dr, cur_hi, cur_lo, m_hi, m_lo;
  logic    m_hi_en, m_lo_en;
  logic    bank_we, bank_hi_en, bank_lo_en;
  logic [IW-1:0] bank_idx;
  logic [W-1:0]  bank_hi, bank_lo;
  logic    done_q, exc_q;
  logic [W-1:0] rd_q;

  assign op_e       = mdu_op_e'(op);
  assign is_div     = op_is_div(op_e);
  assign is_mf      = op_is_mf(op_e);
  assign accept     = start && !div_busy;
  assign mf_nop     = is_mf && dst_zero;
  assign needs_chk  = !is_div && !mf_nop && (acc_idx != '0);
  assign illegal    = accept && needs_chk && !dsp_en;
  assign op_fire    = accept && !illegal && !is_div && !mf_nop;
  assign div_launch = accept && is_div;

  mdu_divider #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .launch(div_launch), .sgn(op_is_signed(op_e)),
    .dividend(opa), .divisor(opb), .busy(div_busy), .last(div_last),
    .quot(dq), .rem(dr)
  );

  mdu_mulacc #(.W(W)) u_mac (
    .op(op_e), .a(opa), .b(opb), .cur_hi(cur_hi), .cur_lo(cur_lo),
    .hi_en(m_hi_en), .lo_en(m_lo_en), .nxt_hi(m_hi), .nxt_lo(m_lo)
  );

  always_comb begin
    if (div_last) begin
      bank_we    = 1'b1;
      bank_idx   = '0;
      bank_hi_en = 1'b1;
      bank_lo_en = 1'b1;
      bank_hi    = dr;
      bank_lo    = dq;
    end else begin
      bank_we    = op_fire && (m_hi_en || m_lo_en);
      bank_idx   = acc_idx;
      bank_hi_en = m_hi_en;
      bank_lo_en = m_lo_en;
      bank_hi    = m_hi;
      bank_lo    = m_lo;
    end
  end

  mdu_acc_bank #(.W(W), .NACC(NACC)) u_bank (
    .clk(clk), .rst_n(rst_n), .rd_idx(acc_idx), .rd_hi(cur_hi), .rd_lo(cur_lo),
    .wr_en(bank_we), .wr_idx(bank_idx), .wr_hi_en(bank_hi_en), .wr_lo_en(bank_lo_en),
    .wr_hi(bank_hi), .wr_lo(bank_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      exc_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      done_q <= (accept && !is_div) || div_last;
      exc_q  <= illegal;
      if (op_fire && is_mf) rd_q <= (op_e == OP_MFHI) ? cur_hi : cur_lo;
    end
  end

  assign busy    = div_busy;
  assign done    = done_q;
  assign dsp_exc = exc_q;
  assign rd_val  = rd_q;

  // R6
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !bank_we);
  // R6
  exc_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_q |-> done_q);
  // R2
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire |=> done_q);
  // R8
  div_no_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_launch |=> !exc_q);
  // R12
  busy_rd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |=> $stable(rd_q));
  // R12
  div_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_last |=> (done_q && !div_busy));
endmodule

// File: tb/tb_acc_mdu.sv
module tb_acc_mdu;
  localparam logic [3:0] C_MULS = 4'd0, C_MULU = 4'd1, C_MADDS = 4'd2, C_MADDU = 4'd3,
                         C_MSUBS = 4'd4, C_MSUBU = 4'd5, C_DIVS = 4'd6, C_DIVU = 4'd7,
                         C_MTHI = 4'd8, C_MTLO = 4'd9, C_MFHI = 4'd10, C_MFLO = 4'd11;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dsp_en = 1'b0, dst_zero = 1'b0;
  logic [3:0] op = '0;
  logic [1:0] acc_idx = '0;
  logic [31:0] opa = '0, opb = '0;
  logic busy, done, dsp_exc;
  logic [31:0] rd_val;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  acc_mdu dut (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .acc_idx(acc_idx),
    .dsp_en(dsp_en), .dst_zero(dst_zero), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .dsp_exc(dsp_exc), .rd_val(rd_val));

  // op, idx, pre_hi, pre_lo, a, b
  localparam int NV = 11;
  localparam logic [133:0] VEC [NV] = '{
    {C_MULS,  2'd1, 32'h0,        32'h0,        32'hFFFFFFF9, 32'h0001E240},
    {C_MULU,  2'd2, 32'h0,        32'h0,        32'hFFFFFFFF, 32'hFFFFFFFF},
    {C_MULS,  2'd0, 32'h0,        32'h0,        32'h80000000, 32'h80000000},
    {C_MADDS, 2'd3, 32'h0,        32'hFFFFFFFF, 32'hFFFFFFFE, 32'h00000003},
    {C_MADDU, 2'd1, 32'h00000001, 32'hFFFFFFF0, 32'hFFFFFFFF, 32'h00000010},
    {C_MSUBS, 2'd2, 32'h0,        32'h0,        32'h00000005, 32'hFFFFFFFD},
    {C_MSUBU, 2'd0, 32'h0,        32'h0,        32'h00000002, 32'h00000003},
    {C_DIVS,  2'd2, 32'h0BAD0000, 32'h00000BAD, 32'hFFFFFF9C, 32'h00000007},
    {C_DIVU,  2'd1, 32'h0C0FFEE0, 32'h0000C0DE, 32'hFFFFFFFF, 32'h0000000A},
    {C_DIVS,  2'd0, 32'h0,        32'h0,        32'h00000064, 32'hFFFFFFF9},
    {C_DIVU,  2'd0, 32'h0,        32'h0,        32'h00BC614E, 32'h00000000}
  };

  function automatic logic [63:0] model(logic [3:0] o, logic [31:0] ph, logic [31:0] pl,
                                        logic [31:0] a, logic [31:0] b);
    longint sa, sb, p, acc;
    int x, y;
    int unsigned ux, uy;
    sa = int'(a); sb = int'(b);
    acc = longint'({ph, pl});
    if (o == C_MULU || o == C_MADDU || o == C_MSUBU)
      p = longint'({32'h0, a}) * longint'({32'h0, b});
    else
      p = sa * sb;
    case (o)
      C_MULS, C_MULU:   return 64'(p);
      C_MADDS, C_MADDU: return 64'(acc + p);
      C_MSUBS, C_MSUBU: return 64'(acc - p);
      C_DIVS: begin
        x = int'(a); y = int'(b);
        if (y == 0 || (x == int'(32'h80000000) && y == -1)) y = 1;
        return {32'(x % y), 32'(x / y)};
      end
      default: begin
        ux = a; uy = b;
        if (uy == 0) uy = 1;
        return {32'(ux % uy), 32'(ux / uy)};
      end
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic [1:0] i, input logic de,
                       input logic dz, input logic [31:0] a, input logic [31:0] b);
    op = o; acc_idx = i; dsp_en = de; dst_zero = dz; opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input logic [3:0] o, input logic [1:0] i, input logic de,
                     input logic dz, input logic [31:0] a, input logic [31:0] b,
                     output int bc);
    drive(o, i, de, dz, a, b);
    bc = 0;
    while (busy && bc < 1000) begin
      bc++;
      @(negedge clk);
    end
  endtask

  task automatic rdacc(input logic [1:0] i, input logic hi, output logic [31:0] v);
    int bc;
    run(hi ? C_MFHI : C_MFLO, i, 1'b1, 1'b0, 32'h0, 32'h0, bc);
    v = rd_val;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, keep;
    logic [63:0] e;
    int bc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'h0, busy}, 32'h0);
    chk("R1 done", {31'h0, done}, 32'h0);
    chk("R1 exc", {31'h0, dsp_exc}, 32'h0);
    chk("R1 rd_val", rd_val, 32'h0);
    for (int k = 0; k < 4; k++) begin
      rdacc(2'(k), 1'b1, v); chk("R1 acc hi", v, 32'h0);
      rdacc(2'(k), 1'b0, v); chk("R1 acc lo", v, 32'h0);
    end

    // Table: R2 R3 multiply forms, R8 R9 R10 divides
    for (int n = 0; n < NV; n++) begin
      logic [3:0] o; logic [1:0] i; logic [31:0] ph, pl, a, b;
      {o, i, ph, pl, a, b} = VEC[n];
      run(C_MTHI, i, 1'b1, 1'b0, ph, 32'h0, bc);
      run(C_MTLO, i, 1'b1, 1'b0, pl, 32'h0, bc);
      e = model(o, ph, pl, a, b);
      run(o, i, 1'b1, 1'b0, a, b, bc);
      chk("R2 done after op", {31'h0, done}, 32'h1);
      if (o == C_DIVS || o == C_DIVU) begin
        chk("R12 busy cycles", 32'(bc), 32'd32);
        rdacc(2'd0, 1'b1, v); chk("R8 R9 R10 div HI", v, e[63:32]);
        rdacc(2'd0, 1'b0, v); chk("R8 R9 R10 div LO", v, e[31:0]);
        if (i != 2'd0) begin
          rdacc(i, 1'b1, v); chk("R8 indexed bank kept HI", v, ph);
          rdacc(i, 1'b0, v); chk("R8 indexed bank kept LO", v, pl);
        end
      end else begin
        rdacc(i, 1'b1, v); chk("R2 R3 HI", v, e[63:32]);
        rdacc(i, 1'b0, v); chk("R2 R3 LO", v, e[31:0]);
      end
    end

    // R4 half writes
    run(C_MTHI, 2'd3, 1'b1, 1'b0, 32'hAAAA0000, 32'h0, bc);
    run(C_MTLO, 2'd3, 1'b1, 1'b0, 32'h00005555, 32'h0, bc);
    run(C_MTHI, 2'd3, 1'b1, 1'b0, 32'h00001234, 32'h0, bc);
    rdacc(2'd3, 1'b0, v); chk("R4 LO kept", v, 32'h00005555);
    rdacc(2'd3, 1'b1, v); chk("R4 HI written", v, 32'h00001234);
    // R5 rd_val holds
    @(negedge clk);
    chk("R5 rd_val held", rd_val, 32'h00001234);

    // R6 illegal write and illegal read
    drive(C_MTLO, 2'd3, 1'b0, 1'b0, 32'hDEADBEEF, 32'h0);
    chk("R6 exc pulse", {31'h0, dsp_exc}, 32'h1);
    chk("R6 done pulse", {31'h0, done}, 32'h1);
    keep = rd_val;
    drive(C_MFLO, 2'd3, 1'b0, 1'b0, 32'h0, 32'h0);
    chk("R6 exc on read", {31'h0, dsp_exc}, 32'h1);
    chk("R6 rd_val unchanged", rd_val, keep);
    @(negedge clk);
    chk("R6 exc one cycle", {31'h0, dsp_exc}, 32'h0);
    rdacc(2'd3, 1'b0, v); chk("R6 acc untouched", v, 32'h00005555);

    // R7 register-zero move-from
    keep = rd_val;
    drive(C_MFHI, 2'd2, 1'b0, 1'b1, 32'h0, 32'h0);
    chk("R7 no exc", {31'h0, dsp_exc}, 32'h0);
    chk("R7 done", {31'h0, done}, 32'h1);
    chk("R7 rd_val unchanged", rd_val, keep);

    // R13 independent banks
    run(C_MTLO, 2'd1, 1'b1, 1'b0, 32'h00000011, 32'h0, bc);
    run(C_MTLO, 2'd2, 1'b1, 1'b0, 32'h00000022, 32'h0, bc);
    run(C_MTLO, 2'd0, 1'b1, 1'b0, 32'h00000099, 32'h0, bc);
    rdacc(2'd1, 1'b0, v); chk("R13 bank1", v, 32'h00000011);
    rdacc(2'd2, 1'b0, v); chk("R13 bank2", v, 32'h00000022);

    // R8 divide with nonzero index and extension off
    drive(C_DIVU, 2'd3, 1'b0, 1'b0, 32'd50, 32'd5);
    chk("R8 no exc", {31'h0, dsp_exc}, 32'h0);
    while (busy) @(negedge clk);
    rdacc(2'd0, 1'b0, v); chk("R8 quotient acc0", v, 32'd10);
    rdacc(2'd0, 1'b1, v); chk("R8 remainder acc0", v, 32'd0);
    rdacc(2'd3, 1'b1, v); chk("R8 bank3 kept", v, 32'h00001234);

    // R10 zero divisor
    run(C_DIVS, 2'd0, 1'b1, 1'b0, 32'hFFFFFFF7, 32'h0, bc);
    rdacc(2'd0, 1'b0, v); chk("R10 signed LO", v, 32'hFFFFFFF7);
    rdacc(2'd0, 1'b1, v); chk("R10 signed HI", v, 32'h0);
    run(C_DIVU, 2'd0, 1'b1, 1'b0, 32'h80000001, 32'h0, bc);
    rdacc(2'd0, 1'b0, v); chk("R10 unsigned LO", v, 32'h80000001);
    // R11 overflow pair
    run(C_DIVS, 2'd0, 1'b1, 1'b0, 32'h80000000, 32'hFFFFFFFF, bc);
    chk("R12 busy count", 32'(bc), 32'd32);
    chk("R12 done at end", {31'h0, done}, 32'h1);
    rdacc(2'd0, 1'b0, v); chk("R11 LO", v, 32'h80000000);
    rdacc(2'd0, 1'b1, v); chk("R11 HI", v, 32'h0);

    // R12 start ignored while busy
    drive(C_DIVU, 2'd0, 1'b1, 1'b0, 32'd100, 32'd3);
    chk("R12 busy after start", {31'h0, busy}, 32'h1);
    drive(C_MTLO, 2'd1, 1'b1, 1'b0, 32'h0000DEAD, 32'h0);
    chk("R12 no done for ignored", {31'h0, done}, 32'h0);
    while (busy) @(negedge clk);
    chk("R12 done after divide", {31'h0, done}, 32'h1);
    rdacc(2'd1, 1'b0, v); chk("R12 ignored write", v, 32'h00000011);
    rdacc(2'd0, 1'b0, v); chk("R9 quotient", v, 32'd33);
    rdacc(2'd0, 1'b1, v); chk("R9 remainder", v, 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule